// File: doc/BRIEF.md
# Serial control-word receiver with prefix-coded register select

This block receives 24-bit control words over a three-wire serial link (serial clock, serial data, latch) and stores them in seven control registers that configure a dual frequency synthesizer. All three serial pins are brought into the core clock domain through a two-flop synchronizer. Rising edges of the serial clock are detected in the core clock domain, and each one shifts one data bit into a holding register, most significant bit first. When the latch pin rises, the held word is written to the register named by an address field at the low end of the word. That field is prefix-coded and is 2 to 6 bits long, so registers with short addresses keep more bits for their data.

The block drives the decoded control fields straight to the analog and divider logic. It also supplies the effective intermediate-frequency (IF) divider values. A default-select bit in register 0 chooses between built-in divider presets, picked by a 2-bit IF plan code and the reference-rate bit, and user values held in registers 4 and 5. While default-select is set, registers 4 to 6 cannot be written. The RF and IF section enables are gated by a chip-enable pin.

Top module: `cfgser_regs`

## Requirements
- R1: A rising edge of `ser_clk` (after synchronization) while `ser_le` is low shifts `ser_dat` into a 24-bit holding word at bit 0, moving earlier bits up. The first bit sent ends up in bit 23.
- R2: A rising edge of `ser_le` writes the holding word to the register picked by its low bits. Reg0 is bits[1:0]=00, reg1 is 01 and reg2 is 10. Reg3 is bits[2:0]=011, reg4 is bits[3:0]=0111, reg5 is bits[4:0]=01111 and reg6 is bits[5:0]=011111. The new values appear at the outputs no more than 4 `clk` cycles after `ser_le` rises.
- R3: A word whose low bits match none of the codes in R2 (for example, low six bits 111111) changes no output.
- R4: `ser_clk` edges that occur while `ser_le` is high do not change the holding word.
- R5: While `dflt_sel` is 1, writes to reg4, reg5 and reg6 are dropped.
- R6: When `dflt_sel` is 1, `if_a`/`if_b` come from `if_plan`: 00 gives 15/88, 01 gives 4/191, 10 gives 9/229 and 11 gives 15/88. In the same case `if_r` is 160, or 164 when `osc_sel` is 1. When `dflt_sel` is 0, all three come from reg4 and reg5.
- R7: `rf_on` and `if_on` are 0 while `chip_en` is 0. Otherwise they follow the RF-enable and IF-enable bits of reg1.
- R8: After reset the outputs are as follows. dflt_sel=1, band_sel=0, lock_det_en=1, spur_fix=0, rf_b=11, rf_a=2, rf_frac=1104. if_plan=10, osc_sel=0, spur_mode=10, out_pwr=00, RF and IF enables 1. pump_cur=00, bw_dur=00, bw_crl=00, bw_en=1, vco_cur=11. User IF A/B/R = 9/229/160, tst_word=0.
- R9: A reg4 write is dropped unless its B field is nonzero and its A field is less than its B field. A reg5 write is dropped unless its R field is at least 2.
- R10: Reg0 holds dflt_sel[23], band_sel[22], lock_det_en[21], spur_fix[20], rf_b[19:16], rf_a[15:13] and rf_frac[12:2]. Reg1 holds if_plan[23:22], osc_sel[21], spur_mode[20:19], out_pwr[18:17], RF enable[16] and IF enable[15].
- R11: Reg2 holds pump_cur[23:22]. Reg3 holds bw_dur[23:22], bw_crl[21:20], bw_en[19] and vco_cur[18:17]. Reg4 holds user A[23:20] and user B[19:11]. Reg5 holds user R[23:15]. Reg6 holds tst_word[23:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| ser_le | input | 1 | Latch; a rising edge writes the word |
| chip_en | input | 1 | Chip enable gating both sections |
| rf_on | output | 1 | RF section enable |
| if_on | output | 1 | IF section enable |
| dflt_sel | output | 1 | Built-in IF presets selected |
| band_sel | output | 1 | RF band select |
| lock_det_en | output | 1 | Lock-detect output enable |
| spur_fix | output | 1 | Spur control bit |
| rf_b | output | 4 | RF programmable counter |
| rf_a | output | 3 | RF swallow counter |
| rf_frac | output | 11 | RF fractional numerator |
| if_plan | output | 2 | IF preset plan code |
| osc_sel | output | 1 | Reference rate select |
| spur_mode | output | 2 | Spur reduction mode |
| out_pwr | output | 2 | RF output level |
| pump_cur | output | 2 | IF charge pump level |
| bw_dur | output | 2 | Bandwidth boost duration |
| bw_crl | output | 2 | Bandwidth boost phase criterion |
| bw_en | output | 1 | Bandwidth boost enable |
| vco_cur | output | 2 | VCO current level |
| if_a | output | 4 | Effective IF swallow count |
| if_b | output | 9 | Effective IF programmable count |
| if_r | output | 9 | Effective IF reference divider |
| tst_word | output | 16 | Test register contents |

## Verification
The assertions assume that the serial pins change far more slowly than `clk`. Each level is held for several core cycles, so no serial-clock or latch edge is lost in the synchronizer. The range assertion also depends on the reset defaults being legal divider values. The stimulus holds every serial level for three core cycles and does not shift while the latch is high, except in the one directed case that tests exactly that. Random words reach all seven addresses and undecodable codes, with random payloads that include illegal IF values, while the chip-enable pin is toggled between words.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
   localparam int WORD_W = 24;
   localparam int NREG   = 7;
   localparam int IFA_W  = 4;
   localparam int IFB_W  = 9;
   localparam int IFR_W  = 9;

   typedef struct packed {
      logic [IFA_W-1:0] a;
      logic [IFB_W-1:0] b;
      logic [IFR_W-1:0] r;
   } if_cnt_t;

   // Built-in IF divider sets; reference divider tracks the reference rate
   function automatic if_cnt_t if_preset(input logic [1:0] plan, input logic osc);
      if_cnt_t c;
      c.r = osc ? IFR_W'(164) : IFR_W'(160);
      case (plan)
         2'b01:   begin c.a = IFA_W'(4);  c.b = IFB_W'(191); end
         2'b10:   begin c.a = IFA_W'(9);  c.b = IFB_W'(229); end
         default: begin c.a = IFA_W'(15); c.b = IFB_W'(88);  end
      endcase
      return c;
   endfunction
endpackage

// File: rtl/cfgser_front.sv
module cfgser_front #(
   parameter int WORD_W = 24,
   parameter int SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_le,
   output logic [WORD_W-1:0] word,
   output logic              commit
);
   localparam int CK_W = SYNC_N + 1;

   if (SYNC_N < 2) begin : g_bad_sync
      $error("cfgser_front: SYNC_N must be at least 2");
   end

   logic [CK_W-1:0]   ck_s, le_s;
   logic [SYNC_N-1:0] dt_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_s <= '0;
         le_s <= '0;
         dt_s <= '0;
      end else begin
         ck_s <= {ck_s[CK_W-2:0], ser_clk};
         le_s <= {le_s[CK_W-2:0], ser_le};
         dt_s <= {dt_s[SYNC_N-2:0], ser_dat};
      end
   end

   logic ck_rise, le_lvl;
   assign ck_rise = ck_s[SYNC_N-1] & ~ck_s[SYNC_N];
   assign le_lvl  = le_s[SYNC_N-1];
   assign commit  = le_s[SYNC_N-1] & ~le_s[SYNC_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 word <= '0;
      else if (ck_rise && !le_lvl) word <= {word[WORD_W-2:0], dt_s[SYNC_N-1]};
   end

   // R4: holding word frozen while latch is high
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      le_lvl |=> $stable(word));
endmodule

// File: rtl/cfgser_addr.sv
module cfgser_addr #(
   parameter int WORD_W = 24,
   parameter int NREG   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word,
   output logic [NREG-1:0]   hit
);
   if (NREG < 3 || NREG - 1 > WORD_W) begin : g_bad_nreg
      $error("cfgser_addr: NREG out of range for WORD_W");
   end

   // Registers 0..2 use 2-bit codes; register k>=3 uses a k-bit code
   // of a zero followed by k-1 ones, which keeps the set prefix-free.
   for (genvar k = 0; k < NREG; k++) begin : g_dec
      localparam int AW = (k < 3) ? 2 : k;
      localparam logic [AW-1:0] PAT = (k < 3) ? AW'(k) : AW'((1 << (k - 1)) - 1);
      assign hit[k] = (word[AW-1:0] == PAT);
   end

   // R2: prefix code never selects two registers
   assert_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
endmodule

// File: rtl/cfgser_regs.sv
module cfgser_regs
   import cfgser_pkg::*;
#(
   parameter bit HAS_PRESETS = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ser_clk,
   input  logic        ser_dat,
   input  logic        ser_le,
   input  logic        chip_en,
   output logic        rf_on,
   output logic        if_on,
   output logic        dflt_sel,
   output logic        band_sel,
   output logic        lock_det_en,
   output logic        spur_fix,
   output logic [3:0]  rf_b,
   output logic [2:0]  rf_a,
   output logic [10:0] rf_frac,
   output logic [1:0]  if_plan,
   output logic        osc_sel,
   output logic [1:0]  spur_mode,
   output logic [1:0]  out_pwr,
   output logic [1:0]  pump_cur,
   output logic [1:0]  bw_dur,
   output logic [1:0]  bw_crl,
   output logic        bw_en,
   output logic [1:0]  vco_cur,
   output logic [IFA_W-1:0] if_a,
   output logic [IFB_W-1:0] if_b,
   output logic [IFR_W-1:0] if_r,
   output logic [15:0] tst_word
);
   localparam int T = WORD_W - 1;

   if (WORD_W < 24) begin : g_bad_word
      $error("cfgser_regs: field map needs WORD_W >= 24");
   end

   logic [WORD_W-1:0] word;
   logic              commit;
   logic [NREG-1:0]   hit;

   cfgser_front #(.WORD_W(WORD_W), .SYNC_N(2)) u_front (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_le(ser_le), .word(word), .commit(commit));

   cfgser_addr #(.WORD_W(WORD_W), .NREG(NREG)) u_addr (
      .clk(clk), .rst_n(rst_n), .word(word), .hit(hit));

   logic rf_en_b, if_en_b;
   logic [IFA_W-1:0] usr_a;
   logic [IFB_W-1:0] usr_b;
   logic [IFR_W-1:0] usr_r;

   logic [IFA_W-1:0] new_a;
   logic [IFB_W-1:0] new_b;
   logic [IFR_W-1:0] new_r;
   assign new_a = word[T -: IFA_W];
   assign new_b = word[T-IFA_W -: IFB_W];
   assign new_r = word[T -: IFR_W];

   logic wr0, wr1, wr2, wr3, wr4, wr5, wr6;
   assign wr0 = commit & hit[0];
   assign wr1 = commit & hit[1];
   assign wr2 = commit & hit[2];
   assign wr3 = commit & hit[3];
   assign wr4 = commit & hit[4] & ~dflt_sel & (new_b != '0)
              & ({{(IFB_W-IFA_W){1'b0}}, new_a} < new_b);
   assign wr5 = commit & hit[5] & ~dflt_sel & (new_r >= IFR_W'(2));
   assign wr6 = commit & hit[6] & ~dflt_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {dflt_sel, band_sel, lock_det_en, spur_fix} <= 4'b1010;
         rf_b <= 4'd11; rf_a <= 3'd2; rf_frac <= 11'd1104;
      end else if (wr0) begin
         {dflt_sel, band_sel, lock_det_en, spur_fix} <= word[T -: 4];
         rf_b    <= word[T-4 -: 4];
         rf_a    <= word[T-8 -: 3];
         rf_frac <= word[T-11 -: 11];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         if_plan <= 2'b10; osc_sel <= 1'b0; spur_mode <= 2'b10;
         out_pwr <= 2'b00; rf_en_b <= 1'b1; if_en_b <= 1'b1;
      end else if (wr1) begin
         if_plan   <= word[T -: 2];
         osc_sel   <= word[T-2];
         spur_mode <= word[T-3 -: 2];
         out_pwr   <= word[T-5 -: 2];
         rf_en_b   <= word[T-7];
         if_en_b   <= word[T-8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pump_cur <= 2'b00;
         bw_dur <= 2'b00; bw_crl <= 2'b00; bw_en <= 1'b1; vco_cur <= 2'b11;
      end else begin
         if (wr2) pump_cur <= word[T -: 2];
         if (wr3) begin
            bw_dur  <= word[T -: 2];
            bw_crl  <= word[T-2 -: 2];
            bw_en   <= word[T-4];
            vco_cur <= word[T-5 -: 2];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         usr_a <= IFA_W'(9); usr_b <= IFB_W'(229); usr_r <= IFR_W'(160);
         tst_word <= '0;
      end else begin
         if (wr4) begin usr_a <= new_a; usr_b <= new_b; end
         if (wr5) usr_r <= new_r;
         if (wr6) tst_word <= word[T -: 16];
      end
   end

   if_cnt_t eff, usr;
   assign usr = '{a: usr_a, b: usr_b, r: usr_r};

   if (HAS_PRESETS) begin : g_preset
      always_comb eff = dflt_sel ? if_preset(if_plan, osc_sel) : usr;
   end else begin : g_user_only
      assign eff = usr;
   end

   assign if_a = eff.a;
   assign if_b = eff.b;
   assign if_r = eff.r;

   assign rf_on = chip_en & rf_en_b;
   assign if_on = chip_en & if_en_b;

   // R5: locked user registers while presets are selected
   assert_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && dflt_sel) |=> $stable({usr_a, usr_b, usr_r, tst_word}));

   // R9: stored user divider values always legal
   assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_b != '0) && ({{(IFB_W-IFA_W){1'b0}}, usr_a} < usr_b) && (usr_r >= IFR_W'(2)));

   // R3: nothing changes without a decoded commit
   assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit && (|hit)) |=> $stable({dflt_sel, band_sel, lock_det_en, spur_fix, rf_b,
         rf_a, rf_frac, if_plan, osc_sel, spur_mode, out_pwr, rf_en_b, if_en_b,
         pump_cur, bw_dur, bw_crl, bw_en, vco_cur, usr_a, usr_b, usr_r, tst_word}));
endmodule

// File: tb/sim_cfgser_regs.sv
module sim_cfgser_regs;
   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0, chip_en = 1'b1;
   logic rf_on, if_on, dflt_sel, band_sel, lock_det_en, spur_fix, osc_sel, bw_en;
   logic [3:0] rf_b, if_a;
   logic [2:0] rf_a;
   logic [10:0] rf_frac;
   logic [1:0] if_plan, spur_mode, out_pwr, pump_cur, bw_dur, bw_crl, vco_cur;
   logic [8:0] if_b, if_r;
   logic [15:0] tst_word;

   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   cfgser_regs u0 (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_le(ser_le), .chip_en(chip_en), .rf_on(rf_on), .if_on(if_on),
      .dflt_sel(dflt_sel), .band_sel(band_sel), .lock_det_en(lock_det_en),
      .spur_fix(spur_fix), .rf_b(rf_b), .rf_a(rf_a), .rf_frac(rf_frac),
      .if_plan(if_plan), .osc_sel(osc_sel), .spur_mode(spur_mode), .out_pwr(out_pwr),
      .pump_cur(pump_cur), .bw_dur(bw_dur), .bw_crl(bw_crl), .bw_en(bw_en),
      .vco_cur(vco_cur), .if_a(if_a), .if_b(if_b), .if_r(if_r), .tst_word(tst_word));

   // Reference model state (reset values per R8)
   logic m_dflt = 1, m_band = 0, m_ld = 1, m_spf = 0;
   logic [3:0] m_b = 11;  logic [2:0] m_a = 2;  logic [10:0] m_fn = 1104;
   logic [1:0] m_plan = 2'b10; logic m_osc = 0; logic [1:0] m_spm = 2'b10, m_pwr = 0;
   logic m_rfe = 1, m_ife = 1;
   logic [1:0] m_pump = 0, m_bwd = 0, m_bwc = 0, m_vco = 2'b11; logic m_bwe = 1;
   logic [3:0] m_ua = 9; logic [8:0] m_ub = 229, m_ur = 160; logic [15:0] m_tst = 0;

   function automatic logic [23:0] mk(int k, logic [23:0] d);
      logic [23:0] w = d;
      case (k)
         0: w[1:0] = 2'b00;
         1: w[1:0] = 2'b01;
         2: w[1:0] = 2'b10;
         3: w[2:0] = 3'b011;
         4: w[3:0] = 4'b0111;
         5: w[4:0] = 5'b01111;
         default: w[5:0] = 6'b011111;
      endcase
      return w;
   endfunction

   function automatic int preset_a(logic [1:0] p);
      return (p == 2'b01) ? 4 : (p == 2'b10) ? 9 : 15;
   endfunction
   function automatic int preset_b(logic [1:0] p);
      return (p == 2'b01) ? 191 : (p == 2'b10) ? 229 : 88;
   endfunction

   task automatic model_apply(logic [23:0] w);
      if (w[1:0] == 2'b00) begin
         {m_dflt, m_band, m_ld, m_spf} = w[23:20];
         m_b = w[19:16]; m_a = w[15:13]; m_fn = w[12:2];
      end else if (w[1:0] == 2'b01) begin
         m_plan = w[23:22]; m_osc = w[21]; m_spm = w[20:19]; m_pwr = w[18:17];
         m_rfe = w[16]; m_ife = w[15];
      end else if (w[1:0] == 2'b10) m_pump = w[23:22];
      else if (w[2:0] == 3'b011) begin
         m_bwd = w[23:22]; m_bwc = w[21:20]; m_bwe = w[19]; m_vco = w[18:17];
      end else if (w[3:0] == 4'b0111) begin
         if (!m_dflt && w[19:11] != 0 && {5'b0, w[23:20]} < w[19:11]) begin
            m_ua = w[23:20]; m_ub = w[19:11];
         end
      end else if (w[4:0] == 5'b01111) begin
         if (!m_dflt && w[23:15] >= 2) m_ur = w[23:15];
      end else if (w[5:0] == 6'b011111) begin
         if (!m_dflt) m_tst = w[23:8];
      end
   endtask

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk(tag, "rf_on", rf_on, chip_en & m_rfe);
      chk(tag, "if_on", if_on, chip_en & m_ife);
      chk(tag, "r0", {dflt_sel, band_sel, lock_det_en, spur_fix, rf_b, rf_a, rf_frac},
          {m_dflt, m_band, m_ld, m_spf, m_b, m_a, m_fn});
      chk(tag, "r1", {if_plan, osc_sel, spur_mode, out_pwr}, {m_plan, m_osc, m_spm, m_pwr});
      chk(tag, "r2r3", {pump_cur, bw_dur, bw_crl, bw_en, vco_cur},
          {m_pump, m_bwd, m_bwc, m_bwe, m_vco});
      chk(tag, "if_a", if_a, m_dflt ? preset_a(m_plan) : int'(m_ua));
      chk(tag, "if_b", if_b, m_dflt ? preset_b(m_plan) : int'(m_ub));
      chk(tag, "if_r", if_r, m_dflt ? (m_osc ? 164 : 160) : int'(m_ur));
      chk(tag, "tst_word", tst_word, m_tst);
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_word(logic [23:0] w);
      for (int i = 23; i >= 0; i--) begin
         ser_dat = w[i]; wait_n(3);
         ser_clk = 1'b1; wait_n(3);
         ser_clk = 1'b0;
      end
   endtask

   task automatic latch();
      ser_le = 1'b1; wait_n(4);
      ser_le = 1'b0; wait_n(4);
   endtask

   task automatic send(logic [23:0] w);
      shift_word(w); latch(); model_apply(w);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [23:0] w;
      void'($urandom(32'd5117));
      wait_n(3); rst_n = 1'b1; wait_n(2);
      check_all("R8 reset");

      // R1 R2 R10: reg0 and reg1 fields, presets off
      send(mk(0, {1'b0, 1'b1, 1'b0, 1'b1, 4'd9, 3'd5, 11'd1680, 2'b00}));
      check_all("R1 R2 R10 reg0");
      send(mk(1, {2'b01, 1'b1, 2'b11, 2'b10, 1'b0, 1'b1, 15'd0}));
      check_all("R10 reg1");
      // R11 reg2..reg6 with presets off
      send(mk(2, {2'b11, 22'd0}));
      send(mk(3, {2'b10, 2'b01, 1'b0, 2'b01, 17'd0}));
      send(mk(4, {4'd7, 9'd300, 11'd0}));
      send(mk(5, {9'd191, 15'd0}));
      send(mk(6, {16'hA5C3, 8'd0}));
      check_all("R11 R6 user");
      // R9: illegal user values
      send(mk(4, {4'd5, 9'd5, 11'd0}));
      send(mk(4, {4'd0, 9'd0, 11'd0}));
      send(mk(5, {9'd1, 15'd0}));
      check_all("R9 illegal dropped");
      // R5: presets on, then user writes, then presets off to observe
      send(mk(0, {1'b1, 1'b0, 1'b1, 1'b0, 4'd11, 3'd2, 11'd1104, 2'b00}));
      check_all("R6 preset plan01 osc1");
      send(mk(4, {4'd2, 9'd40, 11'd0}));
      send(mk(5, {9'd77, 15'd0}));
      send(mk(6, {16'h1234, 8'd0}));
      send(mk(0, {1'b0, 1'b0, 1'b1, 1'b0, 4'd11, 3'd2, 11'd1104, 2'b00}));
      check_all("R5 locked writes");
      // R3: undecodable word
      send({18'h3FFFF, 6'b111111});
      check_all("R3 no match");
      // R4: edges while latch high
      send(mk(2, {2'b01, 22'd0}));
      ser_le = 1'b1; wait_n(4);
      for (int i = 0; i < 5; i++) begin
         ser_dat = 1'b1; wait_n(3); ser_clk = 1'b1; wait_n(3); ser_clk = 1'b0;
      end
      ser_le = 1'b0; wait_n(4);
      latch();
      check_all("R4 latch-high edges");
      // R7: chip enable gating
      chip_en = 1'b0; wait_n(1);
      check_all("R7 ce low");
      chip_en = 1'b1;
      send(mk(1, {2'b10, 1'b0, 2'b10, 2'b00, 1'b0, 1'b1, 15'd0}));
      check_all("R7 ce high rf off");

      // Random words across every address and undecodable codes
      for (int it = 0; it < 60; it++) begin
         int k = $urandom_range(0, 7);
         logic [23:0] d = 24'($urandom);
         w = (k == 7) ? {d[23:6], 6'b111111} : mk(k, d);
         if ($urandom_range(0, 3) == 0) chip_en = ~chip_en;
         send(w);
         check_all("R10/R11 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule